// File: doc/BRIEF.md
# Interrupt Priority and Vector Resolver

This block picks one winner among all pending interrupt requests of a processor core and reports the vector address the core fetches its handler pointer from, together with a one-hot acknowledge that the source logic uses to clear the winner's request bit. Five requests have no control register and no programmable level: reset, NMI, watchdog, zero-divide and address-match. All other sources are maskable. Each maskable source carries a software-programmed 3-bit level, which is compared against the processor's current priority threshold.

The core raises `accept` for one cycle when it is ready to take an interrupt. On the next clock edge the block registers the result. If any request qualified, `valid_q` rises, `vec_q` holds the winner's 16-bit vector address and exactly one bit of `ack_q` is set. Vector slots are two bytes wide and descend from the top of memory. The two slots held for debug traps are never produced.

Top module: `irq_vector_resolver`

## Requirements
- R1: While `rst_n` is low, `valid_q` is 0, `ack_q` is all zeros and `vec_q` is 0x0000.
- R2: A reset request beats every other request and yields vector 0xFFFE with `ack_q` bit 0.
- R3: Without reset, NMI (vector 0xFFF4, ack bit 3) beats the watchdog (vector 0xFFF6, ack bit 2), and the watchdog beats every remaining source.
- R4: Below the watchdog come zero-divide (vector 0xFFFC, ack bit 1) and then address-match (vector 0xFFCA, ack bit 22). Both are taken regardless of the priority threshold, and both rank above every maskable source.
- R5: Maskable source i (0 to 17) has vector 0xFFF2 − 2·i and ack bit 4+i. Its level is `level_flat[3i+2:3i]`.
- R6: A maskable source qualifies only if its level is strictly greater than `ipl`. Level 0 therefore never qualifies.
- R7: Among qualifying maskable sources, the one with the highest level wins.
- R8: When qualifying maskable sources tie on level, the lower index wins, which is the higher vector address.
- R9: Results appear on the clock edge after the cycle in which `accept` is high. In a cycle after one without `accept`, `valid_q` and `ack_q` are 0 and `vec_q` keeps its value.
- R10: `ack_q` never has more than one bit set, and `valid_q` is 1 exactly when one bit of `ack_q` is set.
- R11: An accept with no qualifying request gives `valid_q`=0 and `ack_q`=0 and leaves `vec_q` unchanged. The debug slots 0xFFFA and 0xFFF8 are never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accept | input | 1 | Core ready to take an interrupt this cycle |
| req_reset | input | 1 | Reset request |
| req_nmi | input | 1 | Non-maskable external request |
| req_wdt | input | 1 | Watchdog request |
| req_zdiv | input | 1 | Zero-divide request |
| req_amatch | input | 1 | Address-match request |
| req_mask | input | 18 | Pending maskable requests, bit i is source i |
| level_flat | input | 54 | 3-bit level per maskable source |
| ipl | input | 3 | Processor priority threshold |
| valid_q | output | 1 | A winner was registered |
| ack_q | output | 23 | One-hot acknowledge of the winner |
| vec_q | output | 16 | Vector address of the winner |

## Verification
Directed cases place each fixed-tier request next to lower-ranked ones, which separates a wrong tier order from a wrong vector or ack bit. Maskable cases with levels equal to, one above and one below `ipl` show where the strict comparison lies. Sources with equal levels at different indices show the tie rule, and level 0 under `ipl` 0 checks the disable. Random mixes of requests, levels and thresholds from a fixed seed cover cases where several rules interact. Idle cycles between accepts show that the outputs are registered and that `vec_q` holds its value.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    // slot numbers counted downward from the top vector, two bytes each
    localparam int unsigned SLOT_RESET = 0;
    localparam int unsigned SLOT_ZDIV  = 1;
    localparam int unsigned SLOT_BRKX  = 2;  // reserved, never granted
    localparam int unsigned SLOT_DBGX  = 3;  // reserved, never granted
    localparam int unsigned SLOT_WDT   = 4;
    localparam int unsigned SLOT_NMI   = 5;
    localparam int unsigned SLOT_MASK0 = 6;

    typedef enum logic [2:0] {
        FX_NONE,
        FX_RESET,
        FX_NMI,
        FX_WDT,
        FX_ZDIV,
        FX_AMATCH
    } fixed_win_e;
endpackage

// File: rtl/ivr_fixed_pick.sv
module ivr_fixed_pick
    import ivr_pkg::*;
(
    input  logic       req_reset,
    input  logic       req_nmi,
    input  logic       req_wdt,
    input  logic       req_zdiv,
    input  logic       req_amatch,
    output fixed_win_e win
);
    always_comb begin
        if (req_reset)       win = FX_RESET;
        else if (req_nmi)    win = FX_NMI;
        else if (req_wdt)    win = FX_WDT;
        else if (req_zdiv)   win = FX_ZDIV;
        else if (req_amatch) win = FX_AMATCH;
        else                 win = FX_NONE;
    end
endmodule

// File: rtl/ivr_mask_arb.sv
module ivr_mask_arb #(
    parameter int unsigned N_MASK = 18,
    parameter int unsigned LVL_W  = 3,
    localparam int unsigned IDX_W = (N_MASK > 1) ? $clog2(N_MASK) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_MASK-1:0]       req,
    input  logic [N_MASK*LVL_W-1:0] levels,
    input  logic [LVL_W-1:0]        ipl,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx,
    output logic [LVL_W-1:0]        lvl
);
    logic [N_MASK-1:0] elig;

    genvar g;
    generate
        for (g = 0; g < N_MASK; g++) begin : g_elig
            // strict compare: level 0 can never exceed any threshold
            assign elig[g] = req[g] && (levels[g*LVL_W +: LVL_W] > ipl);
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        idx = '0;
        lvl = '0;
        for (int i = 0; i < N_MASK; i++) begin
            // only a strictly higher level displaces: ties keep the lower index
            if (elig[i] && (!hit || levels[i*LVL_W +: LVL_W] > lvl)) begin
                hit = 1'b1;
                idx = IDX_W'(i);
                lvl = levels[i*LVL_W +: LVL_W];
            end
        end
    end

    AST_WIN_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (lvl > ipl) && req[idx]) else $error("winner not eligible"); // R6
endmodule

// File: rtl/irq_vector_resolver.sv
module irq_vector_resolver
    import ivr_pkg::*;
#(
    parameter int unsigned N_MASK     = 18,
    parameter int unsigned LVL_W      = 3,
    parameter int unsigned VEC_W      = 16,
    parameter logic [15:0] TOP_VEC    = 16'hFFFE,
    parameter logic [15:0] AMATCH_VEC = 16'hFFCA
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept,
    input  logic                       req_reset,
    input  logic                       req_nmi,
    input  logic                       req_wdt,
    input  logic                       req_zdiv,
    input  logic                       req_amatch,
    input  logic [N_MASK-1:0]          req_mask,
    input  logic [N_MASK*LVL_W-1:0]    level_flat,
    input  logic [LVL_W-1:0]           ipl,
    output logic                       valid_q,
    output logic [N_MASK+4:0]          ack_q,
    output logic [VEC_W-1:0]           vec_q
);
    localparam int unsigned NSRC      = N_MASK + 5;
    localparam int unsigned IDX_W     = (N_MASK > 1) ? $clog2(N_MASK) : 1;
    // ack bit order follows descending vector address
    localparam int unsigned BIT_RESET = 0;
    localparam int unsigned BIT_ZDIV  = 1;
    localparam int unsigned BIT_WDT   = 2;
    localparam int unsigned BIT_NMI   = 3;
    localparam int unsigned BIT_MASK0 = 4;
    localparam int unsigned BIT_AMAT  = N_MASK + 4;

    typedef struct packed {
        logic             valid;
        logic [NSRC-1:0]  ack;
        logic [VEC_W-1:0] vec;
    } res_t;

    res_t       res_d, res_q;
    fixed_win_e fx_win;
    logic       m_hit;
    logic [IDX_W-1:0] m_idx;
    logic [LVL_W-1:0] m_lvl;

    function automatic logic [VEC_W-1:0] slot_vec(input int unsigned slot);
        return VEC_W'(TOP_VEC) - VEC_W'(2 * slot);
    endfunction

    ivr_fixed_pick u_fixed (
        .req_reset (req_reset),
        .req_nmi   (req_nmi),
        .req_wdt   (req_wdt),
        .req_zdiv  (req_zdiv),
        .req_amatch(req_amatch),
        .win       (fx_win)
    );

    ivr_mask_arb #(.N_MASK(N_MASK), .LVL_W(LVL_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_mask),
        .levels(level_flat),
        .ipl   (ipl),
        .hit   (m_hit),
        .idx   (m_idx),
        .lvl   (m_lvl)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        res_d.ack   = '0;
        if (accept) begin
            res_d.valid = 1'b1;
            unique case (fx_win)
                FX_RESET: begin
                    res_d.ack[BIT_RESET] = 1'b1;
                    res_d.vec = slot_vec(SLOT_RESET);
                end
                FX_NMI: begin
                    res_d.ack[BIT_NMI] = 1'b1;
                    res_d.vec = slot_vec(SLOT_NMI);
                end
                FX_WDT: begin
                    res_d.ack[BIT_WDT] = 1'b1;
                    res_d.vec = slot_vec(SLOT_WDT);
                end
                FX_ZDIV: begin
                    res_d.ack[BIT_ZDIV] = 1'b1;
                    res_d.vec = slot_vec(SLOT_ZDIV);
                end
                FX_AMATCH: begin
                    res_d.ack[BIT_AMAT] = 1'b1;
                    res_d.vec = VEC_W'(AMATCH_VEC);
                end
                default: begin
                    if (m_hit) begin
                        res_d.ack[BIT_MASK0 + 32'(m_idx)] = 1'b1;
                        res_d.vec = slot_vec(SLOT_MASK0 + 32'(m_idx));
                    end else begin
                        res_d.valid = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign valid_q = res_q.valid;
    assign ack_q   = res_q.ack;
    assign vec_q   = res_q.vec;

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_q) && (valid_q == ($countones(ack_q) == 1))) else $error("ack"); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !valid_q && $stable(vec_q)) else $error("idle"); // R9
    AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_reset |=> ack_q[BIT_RESET] && vec_q == VEC_W'(TOP_VEC)) else $error("rst"); // R2
    AST_NMI_OVER_WDT: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !req_reset && req_nmi |=> ack_q[BIT_NMI] && !ack_q[BIT_WDT]) else $error("nmi"); // R3
    AST_NO_DEBUG_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> vec_q != slot_vec(SLOT_BRKX) && vec_q != slot_vec(SLOT_DBGX)) else $error("dbg"); // R11
endmodule

// File: tb/irq_vector_resolver_test.sv
module irq_vector_resolver_test;
    localparam int N      = 18;
    localparam int NS     = N + 5;
    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic accept = 1'b0;
    logic r_rst = 1'b0, r_nmi = 1'b0, r_wdt = 1'b0, r_zdiv = 1'b0, r_am = 1'b0;
    logic [N-1:0]   mreq = '0;
    logic [3*N-1:0] lv   = '0;
    logic [2:0]     ipl  = '0;
    logic           valid_q;
    logic [NS-1:0]  ack_q;
    logic [15:0]    vec_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    irq_vector_resolver uut (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_reset(r_rst), .req_nmi(r_nmi), .req_wdt(r_wdt),
        .req_zdiv(r_zdiv), .req_amatch(r_am), .req_mask(mreq),
        .level_flat(lv), .ipl(ipl),
        .valid_q(valid_q), .ack_q(ack_q), .vec_q(vec_q)
    );

    // expected ack bit: 0 reset,1 zdiv,2 wdt,3 nmi,4+i maskable,4+N amatch; -1 none
    function automatic int model_bit();
        int best;
        int bl;
        if (r_rst)  return 0;
        if (r_nmi)  return 3;
        if (r_wdt)  return 2;
        if (r_zdiv) return 1;
        if (r_am)   return 4 + N;
        best = -1;
        bl = -1;
        for (int i = 0; i < N; i++) begin
            int l;
            l = int'(lv[3*i +: 3]);
            if (mreq[i] && l > int'(ipl) && l > bl) begin
                best = i;
                bl = l;
            end
        end
        return (best < 0) ? -1 : 4 + best;
    endfunction

    function automatic logic [15:0] model_vec(input int b);
        case (b)
            0: return 16'hFFFE;
            1: return 16'hFFFC;
            2: return 16'hFFF6;
            3: return 16'hFFF4;
            default: return (b == 4 + N) ? 16'hFFCA : 16'hFFF2 - 16'(2 * (b - 4));
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_reqs();
        r_rst = 0; r_nmi = 0; r_wdt = 0; r_zdiv = 0; r_am = 0;
        mreq = '0; lv = '0; ipl = '0;
    endtask

    logic [15:0] last_vec = '0;

    // drive at negedge with accept, check at the following negedge, then idle one cycle
    task automatic run_case(input string req);
        int b;
        logic [NS-1:0] eack;
        logic [15:0]   evec;
        b = model_bit();
        eack = '0;
        evec = last_vec;
        if (b >= 0) begin
            eack[b] = 1'b1;
            evec = model_vec(b);
        end
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
        chk(req, 64'(valid_q), 64'(b >= 0));
        chk(req, 64'(ack_q), 64'(eack));
        chk(req, 64'(vec_q), 64'(evec));
        last_vec = evec;
        @(negedge clk);
        chk("R9 idle", 64'({valid_q, ack_q}), 64'(0));
        chk("R9 hold", 64'(vec_q), 64'(evec));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (2) @(negedge clk);
        chk("R1 valid", 64'(valid_q), 64'(0));
        chk("R1 ack", 64'(ack_q), 64'(0));
        chk("R1 vec", 64'(vec_q), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R11: nothing pending
        clear_reqs(); run_case("R11 none");
        // R2: reset beats all
        clear_reqs(); r_rst = 1; r_nmi = 1; r_wdt = 1; mreq = '1; lv = '1; run_case("R2");
        // R3: nmi over watchdog
        clear_reqs(); r_nmi = 1; r_wdt = 1; r_zdiv = 1; run_case("R3 nmi");
        clear_reqs(); r_wdt = 1; r_zdiv = 1; r_am = 1; mreq = '1; lv = '1; run_case("R3 wdt");
        // R4: zero-divide and address-match ignore ipl, beat maskables
        clear_reqs(); r_zdiv = 1; r_am = 1; ipl = 3'd7; run_case("R4 zdiv");
        clear_reqs(); r_am = 1; ipl = 3'd7; mreq = '1; lv = '1; run_case("R4 amatch");
        // R6: level equal to ipl rejected, one above accepted, level 0 disabled
        clear_reqs(); mreq[5] = 1; lv[15 +: 3] = 3'd4; ipl = 3'd4; run_case("R6 equal");
        clear_reqs(); mreq[5] = 1; lv[15 +: 3] = 3'd5; ipl = 3'd4; run_case("R6 above");
        clear_reqs(); mreq[0] = 1; lv[0 +: 3] = 3'd0; run_case("R6 level0");
        // R7: highest level wins over lower index
        clear_reqs(); mreq[1] = 1; lv[3 +: 3] = 3'd2; mreq[17] = 1; lv[51 +: 3] = 3'd6; run_case("R7");
        // R8: tie goes to the lower index
        clear_reqs(); mreq[9] = 1; lv[27 +: 3] = 3'd3; mreq[4] = 1; lv[12 +: 3] = 3'd3; run_case("R8");
        // R5: every maskable slot alone
        for (int i = 0; i < N; i++) begin
            clear_reqs(); mreq[i] = 1; lv[3*i +: 3] = 3'd1; run_case("R5 slot");
        end
        // random mix, R7 R8 R10 together
        for (int k = 0; k < 400; k++) begin
            clear_reqs();
            r_rst  = ($urandom % 32) == 0;
            r_nmi  = ($urandom % 16) == 0;
            r_wdt  = ($urandom % 16) == 0;
            r_zdiv = ($urandom % 16) == 0;
            r_am   = ($urandom % 16) == 0;
            mreq   = N'($urandom) & N'($urandom);
            for (int i = 0; i < N; i++) lv[3*i +: 3] = 3'($urandom);
            ipl = 3'($urandom);
            run_case("R10 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule